// File: doc/BRIEF.md
# Single-Frame Capture and Readout Buffer

This block takes a small image sensor's pixel stream and, when the host arms it, stores one complete frame of 400 eight-bit pixels in an internal buffer. Capture begins at the first frame-start marker after arming. It is single-shot: frames that arrive after the buffer is full are not stored.

Once the frame is stored, a ready flag tells the host to fetch it. The host reads one data register over and over. Each read returns the next stored pixel, so 400 reads return the whole frame in order. When the last pixel has been read, the block reports that the upload is complete.

Next to the buffer, a peak detector follows the largest pixel value of the current frame. It runs whether or not a capture is armed, so the host can check for saturation at any time. The register port is byte wide and uses an address, a read strobe and a write strobe. Read data appears one clock after the read strobe.

Top module: `frame_dump_buf`

## Requirements
- R1: After reset, every control and status bit is 0, the peak register is 0, and the read data output is 0.
- R2: Writing a value with bit 0 set to address 0 while the block is disarmed arms it, and bit 0 of address 0 then reads back 1. Bits 1 to 3 of a write are ignored. Writing bit 0 set while already armed changes nothing. With the block disarmed, no pixel is stored.
- R3: Capture begins at the first cycle with the frame-start marker after arming. From that cycle on, bit 1 of address 0 (started) reads 1. Pixels that arrive before that marker are not stored.
- R4: Each pixel with the valid strobe high during capture is stored at the next address, counting up from 0. Cycles without the valid strobe store nothing and do not advance the write address.
- R5: After the 400th stored pixel, bit 2 of address 0 (ready) reads 1. Frames that arrive later are not captured.
- R6: While ready is 1, each read of address 1 returns the next stored pixel in capture order.
- R7: Once the 400th pixel has been read, ready reads 0 and bit 3 of address 0 (upload complete) reads 1.
- R8: A read of address 1 while ready is 0 returns 0 and does not advance the read position.
- R9: Writing address 0 with bit 0 clear disarms the block. This clears the started, ready and complete flags and returns both pointers to 0. After re-arming, the next capture and readout begin again at pixel 0.
- R10: Address 2 holds the peak pixel value. On a frame-start cycle it restarts from that cycle's pixel, or from 0 if that cycle has no valid pixel. After that it keeps the maximum of all valid pixels, whether or not the block is armed.
- R11: Read data is registered and is valid on the clock after the read strobe. Address 0 returns {complete, ready, started, enable} in bits 3:0, with 0 above them. Address 3 returns 0. Writes to any address other than 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_sof | input | 1 | Frame-start marker, high on the first pixel cycle of a frame |
| pix_valid | input | 1 | Pixel strobe, high when pix_data carries a pixel |
| pix_data | input | 8 | Pixel value |
| reg_addr | input | 2 | Register address: 0 control/status, 1 pixel data, 2 peak |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data, valid the clock after reg_rd |

## Verification
The assertions assume that the host never raises the read and write strobes in the same cycle. They also assume that the host never writes the control register in a cycle that carries a frame-start marker, and that no new frame-start marker arrives before a capture has stored its 400 pixels. The stimulus drives register accesses and pixel bursts from separate tasks that never overlap, so these cases cannot occur. The stimulus places idle cycles inside one frame to exercise the write pointer holding. It sends frames while disarmed, sends stray pixels before the marker, and aborts both in the middle of a capture and in the middle of a download.

// File: rtl/fdb_pkg.sv
// Package: shared types and register map for the frame dump buffer.
// Assumes a 2-bit register address space.
package fdb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_CAPT,
        ST_READY,
        ST_DONE
    } dump_state_e;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_DATA = 2'd1;
    localparam logic [1:0] REG_PEAK = 2'd2;

    localparam int BIT_EN    = 0;
    localparam int BIT_START = 1;
    localparam int BIT_READY = 2;
    localparam int BIT_DONE  = 3;

endpackage

// File: rtl/fdb_pixel_store.sv
// Module: frame pixel buffer. One write port driven by capture and one
// asynchronous read port driven by the readout pointer.
// Assumes the controller never writes and reads the same entry in one cycle.
module fdb_pixel_store #(
    parameter int DEPTH = 400,
    parameter int PIX_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [PIX_W-1:0] wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [PIX_W-1:0] rdata
);

    logic [PIX_W-1:0] mem [DEPTH];

    // Store one pixel per write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the entry at the readout pointer.
    always_comb begin
        rdata = mem[raddr];
    end

endmodule

// File: rtl/fdb_peak_track.sv
// Module: per-frame peak detector. It restarts on the frame-start marker
// and keeps the largest valid pixel, independent of the capture state.
// Assumes pix_sof marks the first pixel cycle of a frame.
module fdb_peak_track #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_sof,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    output logic [PIX_W-1:0] peak
);

    // Restart at frame start, otherwise keep the running maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak <= '0;
        end else if (pix_sof) begin
            peak <= pix_valid ? pix_data : '0;
        end else if (pix_valid && (pix_data > peak)) begin
            peak <= pix_data;
        end
    end

endmodule

// File: rtl/fdb_dump_ctrl.sv
// Module: arm/capture/download sequencer. It owns the enable and started
// flags, the write and read pointers, and the state that drives ready and
// complete.
// Assumes control writes and frame-start markers never share a cycle.
module fdb_dump_ctrl
    import fdb_pkg::*;
#(
    parameter int DEPTH = 400,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             ctrl_wbit,
    input  logic             data_rd,
    input  logic             pix_sof,
    input  logic             pix_valid,
    output logic             en,
    output logic             started,
    output logic             ready,
    output logic             done,
    output logic             rd_hit,
    output logic             cap_we,
    output logic [PTR_W-1:0] cap_addr,
    output logic [PTR_W-1:0] rd_addr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    dump_state_e      state;
    logic             en_q;
    logic             start_q;
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;
    logic             capturing;
    logic             can_start;

    // Decode the capture window and the strobes that leave the sequencer.
    always_comb begin
        capturing = (state == ST_CAPT);
        can_start = (state == ST_ARMED) || capturing;
        rd_hit    = data_rd && (state == ST_READY);
        cap_we    = pix_valid && (pix_sof ? can_start : capturing);
        cap_addr  = pix_sof ? '0 : wptr;
        rd_addr   = rptr;
        en        = en_q;
        started   = start_q;
        ready     = (state == ST_READY);
        done      = (state == ST_DONE);
    end

    // Advance the sequencer: abort, arm, capture and download.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            en_q    <= 1'b0;
            start_q <= 1'b0;
            wptr    <= '0;
            rptr    <= '0;
        end else if (ctrl_wr && !ctrl_wbit) begin
            state   <= ST_IDLE;
            en_q    <= 1'b0;
            start_q <= 1'b0;
            wptr    <= '0;
            rptr    <= '0;
        end else begin
            if (ctrl_wr && !en_q) begin
                en_q  <= 1'b1;
                state <= ST_ARMED;
            end
            case (state)
                ST_ARMED, ST_CAPT: begin
                    if (pix_sof) begin
                        start_q <= 1'b1;
                        state   <= ST_CAPT;
                        wptr    <= pix_valid ? PTR_W'(1) : '0;
                    end else if (capturing && pix_valid) begin
                        if (wptr == LAST) begin
                            state <= ST_READY;
                            wptr  <= '0;
                        end else begin
                            wptr <= wptr + 1'b1;
                        end
                    end
                end
                ST_READY: begin
                    if (rd_hit) begin
                        if (rptr == LAST) begin
                            state <= ST_DONE;
                            rptr  <= '0;
                        end else begin
                            rptr <= rptr + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/frame_dump_buf.sv
// Module: top of the single-frame capture and readout buffer. It decodes
// the register port, registers the read data and joins the sequencer,
// pixel store and peak detector.
// Assumes reg_rd and reg_wr are never high together.
module frame_dump_buf
    import fdb_pkg::*;
#(
    parameter int FRAME_PIXELS = 400,
    parameter int PIX_W        = 8,
    localparam int PTR_W       = $clog2(FRAME_PIXELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_sof,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [PIX_W-1:0] reg_wdata,
    output logic [PIX_W-1:0] reg_rdata
);

    logic             ctrl_wr;
    logic             data_rd;
    logic             flag_en;
    logic             flag_start;
    logic             flag_ready;
    logic             flag_done;
    logic             rd_hit;
    logic             cap_we;
    logic [PTR_W-1:0] cap_addr;
    logic [PTR_W-1:0] rd_addr;
    logic [PIX_W-1:0] mem_q;
    logic [PIX_W-1:0] peak_val;
    logic [PIX_W-1:0] status;
    logic             unused_wbits;

    // Decode register strobes and assemble the status byte.
    always_comb begin
        ctrl_wr           = reg_wr && (reg_addr == REG_CTRL);
        data_rd           = reg_rd && (reg_addr == REG_DATA);
        status            = '0;
        status[BIT_EN]    = flag_en;
        status[BIT_START] = flag_start;
        status[BIT_READY] = flag_ready;
        status[BIT_DONE]  = flag_done;
        unused_wbits      = ^reg_wdata[PIX_W-1:1];
    end

    fdb_dump_ctrl #(.DEPTH(FRAME_PIXELS)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_wbit (reg_wdata[0]),
        .data_rd   (data_rd),
        .pix_sof   (pix_sof),
        .pix_valid (pix_valid),
        .en        (flag_en),
        .started   (flag_start),
        .ready     (flag_ready),
        .done      (flag_done),
        .rd_hit    (rd_hit),
        .cap_we    (cap_we),
        .cap_addr  (cap_addr),
        .rd_addr   (rd_addr)
    );

    fdb_pixel_store #(.DEPTH(FRAME_PIXELS), .PIX_W(PIX_W)) i_store (
        .clk   (clk),
        .we    (cap_we),
        .waddr (cap_addr),
        .wdata (pix_data),
        .raddr (rd_addr),
        .rdata (mem_q)
    );

    fdb_peak_track #(.PIX_W(PIX_W)) i_peak (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_sof   (pix_sof),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .peak      (peak_val)
    );

    // Register the read data selected by the address on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                REG_CTRL: reg_rdata <= status;
                REG_DATA: reg_rdata <= rd_hit ? mem_q : '0;
                REG_PEAK: reg_rdata <= peak_val;
                default:  reg_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/frame_dump_buf_chk.sv
// Module: property checker for frame_dump_buf, attached by bind.
// Assumes the input rules listed in the brief.
module frame_dump_buf_chk #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_sof,
    input logic             pix_valid,
    input logic [PIX_W-1:0] pix_data,
    input logic [1:0]       reg_addr,
    input logic             reg_rd,
    input logic [PIX_W-1:0] reg_rdata,
    input logic             flag_en,
    input logic             flag_start,
    input logic             flag_ready,
    input logic             flag_done,
    input logic [PIX_W-1:0] peak_val
);

    p_disarmed_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_en |-> (!flag_start && !flag_ready && !flag_done));

    p_ready_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_ready) |-> (flag_start && flag_en));

    p_done_follows_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_done) |-> $past(flag_ready));

    p_ready_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_ready && flag_done));

    p_idle_data_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == 2'd1) && !flag_ready) |=> (reg_rdata == '0));

    p_peak_holds_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_sof) |=> (peak_val >= $past(pix_data)));

    p_sof_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_sof && pix_valid) |=> (peak_val == $past(pix_data)));

endmodule

bind frame_dump_buf frame_dump_buf_chk #(.PIX_W(PIX_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_sof    (pix_sof),
    .pix_valid  (pix_valid),
    .pix_data   (pix_data),
    .reg_addr   (reg_addr),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .flag_en    (flag_en),
    .flag_start (flag_start),
    .flag_ready (flag_ready),
    .flag_done  (flag_done),
    .peak_val   (peak_val)
);

// File: tb/test_frame_dump_buf.sv
// Bench: drives pixel frames and register accesses and compares reg_rdata
// against a behavioural model on every clock, plus targeted checks.
module test_frame_dump_buf;

    localparam int NPIX = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_sof = 1'b0;
    logic       pix_valid = 1'b0;
    logic [7:0] pix_data = '0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    frame_dump_buf i_frame_dump_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_sof   (pix_sof),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pixval(input int seed, input int i);
        return 8'((i * seed + 17 * seed) % 256);
    endfunction

    function automatic int peak_of(input int seed, input int n);
        int m = 0;
        for (int i = 0; i < n; i++) if (int'(pixval(seed, i)) > m) m = int'(pixval(seed, i));
        return m;
    endfunction

    // Behavioural reference model
    bit         m_en, m_start, m_ready, m_done, m_cap;
    logic [7:0] m_q[$];
    logic [7:0] m_peak = '0;
    logic [7:0] m_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_start = 0; m_ready = 0; m_done = 0; m_cap = 0;
            m_q.delete(); m_peak = '0; m_rdata = '0;
        end else begin
            if (reg_rd) begin
                case (reg_addr)
                    2'd0: m_rdata = {4'b0, m_done, m_ready, m_start, m_en};
                    2'd1: begin
                        if (m_ready) begin
                            m_rdata = m_q.pop_front();
                            if (m_q.size() == 0) begin m_ready = 0; m_done = 1; end
                        end else m_rdata = '0;
                    end
                    2'd2: m_rdata = m_peak;
                    default: m_rdata = '0;
                endcase
            end
            if (reg_wr && reg_addr == 2'd0) begin
                if (!reg_wdata[0]) begin
                    m_en = 0; m_start = 0; m_ready = 0; m_done = 0; m_cap = 0; m_q.delete();
                end else if (!m_en) m_en = 1;
            end
            if (pix_sof) m_peak = pix_valid ? pix_data : 8'h00;
            else if (pix_valid && pix_data > m_peak) m_peak = pix_data;
            if (pix_sof && m_en && !m_ready && !m_done && (!m_start || m_cap)) begin
                m_start = 1; m_cap = 1; m_q.delete();
            end
            if (m_cap && pix_valid) begin
                m_q.push_back(pix_data);
                if (m_q.size() == NPIX) begin m_cap = 0; m_ready = 1; end
            end
        end
    end

    // R11 per-cycle comparison against the model
    always @(negedge clk) begin
        check(reg_rdata === m_rdata, "R11 per-cycle model", int'(reg_rdata), int'(m_rdata));
    end

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
    endtask

    task automatic rd_chk(input logic [1:0] a, input int exp, input string tag);
        logic [7:0] v;
        rd(a, v);
        check(int'(v) == exp, tag, int'(v), exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic send(input int seed, input int first, input int n, input bit sof, input int gap);
        for (int i = first; i < first + n; i++) begin
            if (gap > 0 && (i % gap) == gap - 1) begin
                @(negedge clk); pix_valid = 1'b0; pix_sof = 1'b0;
            end
            @(negedge clk);
            pix_sof = sof && (i == first);
            pix_valid = 1'b1;
            pix_data = pixval(seed, i);
        end
        @(negedge clk); pix_valid = 1'b0; pix_sof = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int pk;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_chk(2'd0, 0, "R1 ctrl after reset");
        rd_chk(2'd2, 0, "R1 peak after reset");
        rd_chk(2'd1, 0, "R8 data read with no frame");
        // Unarmed frame: peak only
        send(3, 0, NPIX, 1'b1, 0);
        rd_chk(2'd0, 0, "R2 unarmed frame not captured");
        rd_chk(2'd2, peak_of(3, NPIX), "R10 peak while disarmed");
        // Arm; upper write bits ignored
        wr(2'd0, 8'h0F);
        rd_chk(2'd0, 1, "R2 enable reads back alone");
        // Stray pixels before the marker
        send(5, 0, 20, 1'b0, 0);
        rd_chk(2'd0, 1, "R3 no start without marker");
        rd_chk(2'd1, 0, "R8 data read while armed");
        pk = peak_of(3, NPIX);
        if (peak_of(5, 20) > pk) pk = peak_of(5, 20);
        rd_chk(2'd2, pk, "R10 peak continues without marker");
        // Frame with gaps, split around a status read
        send(7, 0, 10, 1'b1, 5);
        rd_chk(2'd0, 3, "R3 started during capture");
        send(7, 10, NPIX - 10, 1'b0, 5);
        rd_chk(2'd0, 7, "R5 ready after last pixel");
        rd_chk(2'd2, peak_of(7, NPIX), "R10 peak of gapped frame");
        // Later frame must not overwrite
        send(9, 0, NPIX, 1'b1, 0);
        rd_chk(2'd0, 7, "R5 single shot keeps ready");
        rd_chk(2'd2, peak_of(9, NPIX), "R10 peak restarts at marker");
        // Download
        for (int i = 0; i < NPIX - 1; i++) rd_chk(2'd1, int'(pixval(7, i)), "R4 R6 pixel order");
        rd_chk(2'd0, 7, "R7 still ready before last read");
        rd_chk(2'd1, int'(pixval(7, NPIX - 1)), "R6 last pixel");
        rd_chk(2'd0, 8'h0B, "R7 complete after last read");
        rd_chk(2'd1, 0, "R8 data read after complete");
        wr(2'd0, 8'h01);
        rd_chk(2'd0, 8'h0B, "R2 re-write while armed no effect");
        wr(2'd0, 8'h00);
        rd_chk(2'd0, 0, "R9 disarm clears flags");
        // Abort mid-capture
        wr(2'd0, 8'h01);
        send(11, 0, 100, 1'b1, 0);
        rd_chk(2'd0, 3, "R3 capture in progress");
        wr(2'd0, 8'h00);
        rd_chk(2'd0, 0, "R9 abort mid-capture");
        // Abort mid-download
        wr(2'd0, 8'h01);
        send(13, 0, NPIX, 1'b1, 0);
        for (int i = 0; i < 3; i++) rd_chk(2'd1, int'(pixval(13, i)), "R6 partial download");
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h01);
        send(15, 0, NPIX, 1'b1, 3);
        rd_chk(2'd0, 7, "R9 re-armed capture ready");
        rd_chk(2'd1, int'(pixval(15, 0)), "R9 readout restarts at pixel 0");
        rd_chk(2'd1, int'(pixval(15, 1)), "R9 second pixel");
        // Register map corners
        wr(2'd1, 8'h00);
        rd_chk(2'd0, 7, "R11 write to data address ignored");
        rd_chk(2'd3, 0, "R11 unused address reads 0");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule